// File: doc/BRIEF.md
# Pulse-Swallowing Decade Pulse Counter

This block counts a preset number of fast input pulses, from 0 to 99, and raises a done flag once exactly that many have been consumed. A two-modulus prescaler divides the accepted pulses by 11 or by 10. Each prescaler wrap is a single-cycle enable that steps a units BCD decade and a tens BCD decade together. Both decades start from the nines' complement of the target digits and count upward.

The units decade reaching 9 does two things: it freezes that decade and it switches the prescaler from divide-by-11 to divide-by-10. A target with tens digit T and units digit U therefore takes U steps of 11 pulses and then T-U steps of 10 pulses, which is 10T+U pulses in total. The decades move only once per 10 or 11 pulses, and everything runs on one clock.

Input pulses arrive on a valid/ready stream. A pulse is consumed on a clock edge where `pulse_valid` and `pulse_ready` are both high. `pulse_ready` depends only on internal state, never on `pulse_valid`. It is low before the first accepted load, after a rejected load, and while done is high. A pulse offered while ready is low is not consumed and stays with the source. The load strobe, the target digits, the done flag, the reject flag and the digit outputs are plain signals.

Top module: `pulse_swallow_counter`

## Requirements
- R1: After reset, `dig_tens` and `dig_units` are 0, and `done`, `pulse_ready` and `bad_target` are low.
- R2: A load with an accepted target sets `dig_tens` to 9-T and `dig_units` to 9-U on the clock edge that samples `load`. The same edge clears `bad_target` and clears the prescaler phase.
- R3: `pulse_ready` is high exactly when a target is armed and `done` is low. A pulse offered while `pulse_ready` is low changes neither the digits nor the pulse tally.
- R4: While `dig_units` is not 9, both digits step up by one after every 11th accepted pulse.
- R5: Once `dig_units` is 9, it stays at 9, and `dig_tens` steps up by one after every 10th accepted pulse.
- R6: `done` first goes high on the edge that consumes accepted pulse number 10T+U, with both digits at 9. A target of 00 raises `done` on the load edge itself.
- R7: After `done` rises, it stays high and the digits stay at 99 until the next load, whatever `pulse_valid` does.
- R8: A load is rejected if either target digit is above 9 or if U is greater than T. A rejected load sets `bad_target`, disarms the counter (so `pulse_ready` goes low) and leaves the digits unchanged.
- R9: A load while counting restarts the count from the new target, discarding any partial prescaler phase.
- R10: Cycles with `pulse_valid` low advance nothing, so gaps anywhere in the pulse stream do not change when `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Load/start strobe; samples the target digits |
| tgt_tens | input | 4 | Target tens digit, BCD |
| tgt_units | input | 4 | Target units digit, BCD |
| pulse_valid | input | 1 | An input pulse is offered this cycle |
| pulse_ready | output | 1 | The counter consumes an offered pulse this cycle |
| done | output | 1 | The target pulse count has been reached |
| bad_target | output | 1 | The last load was rejected |
| dig_tens | output | 4 | Tens decade value |
| dig_units | output | 4 | Units decade value |

## Verification
Every accepted target from 00 to 99 is loaded. Each one is fed once as an unbroken pulse stream and once with irregular gaps. After every accepted pulse, both digits are compared with the values predicted from the divide-by-11 and divide-by-10 phases. This separates errors in the modulus switch point from off-by-one errors in the done instant.

Extra pulses offered after done, and pulses offered after a rejected load, show whether back-pressure really blocks consumption. A reload issued in the middle of a run with a nonzero prescaler phase shows whether the partial phase is discarded.

// File: rtl/pulse_swallow_pkg.sv
package pulse_swallow_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;
  localparam int NUM_DECADES = 2;

  function automatic logic [DIGIT_W-1:0] nines_comp(input logic [DIGIT_W-1:0] d);
    return DIGIT_TOP - d;
  endfunction

  function automatic logic target_ok(input logic [DIGIT_W-1:0] tens,
                                     input logic [DIGIT_W-1:0] units);
    return (tens <= DIGIT_TOP) && (units <= DIGIT_TOP) && (units <= tens);
  endfunction
endpackage

// File: rtl/swallow_prescaler.sv
module swallow_prescaler #(
  parameter int MOD_HI = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  input  logic div_lo,
  output logic tick
);
  localparam int MOD_LO = MOD_HI - 1;
  localparam int CW = $clog2(MOD_HI);
  localparam logic [CW-1:0] LAST_HI = CW'(MOD_HI - 1);
  localparam logic [CW-1:0] LAST_LO = CW'(MOD_LO - 1);

  logic [CW-1:0] phase;
  logic [CW-1:0] last;

  assign last = div_lo ? LAST_LO : LAST_HI;
  assign tick = adv && (phase == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (clear)  phase <= '0;
    else if (adv)    phase <= tick ? '0 : phase + 1'b1;
  end

  a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST_HI);
  a_r3_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !adv) |=> $stable(phase));
  a_r2_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (phase == '0));
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import pulse_swallow_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               preset,
  input  logic [DIGIT_W-1:0] preset_val,
  input  logic               step,
  output logic [DIGIT_W-1:0] digit,
  output logic               at_top
);
  assign at_top = (digit == DIGIT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       digit <= '0;
    else if (preset)  digit <= preset_val;
    else if (step)    digit <= at_top ? '0 : digit + 1'b1;
  end

  a_r4_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
    digit <= DIGIT_TOP);
  a_r2_preset_taken: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (digit == $past(preset_val)));
  a_r10_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset && !step) |=> $stable(digit));
endmodule

// File: rtl/pulse_swallow_counter.sv
module pulse_swallow_counter
  import pulse_swallow_pkg::*;
#(
  parameter int MOD_HI = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DIGIT_W-1:0] tgt_tens,
  input  logic [DIGIT_W-1:0] tgt_units,
  input  logic               pulse_valid,
  output logic               pulse_ready,
  output logic               done,
  output logic               bad_target,
  output logic [DIGIT_W-1:0] dig_tens,
  output logic [DIGIT_W-1:0] dig_units
);
  localparam int UNITS = 0;
  localparam int TENS  = 1;

  logic armed;
  logic load_ok;
  logic accept;
  logic tick;
  logic [NUM_DECADES-1:0] at_top;
  logic [NUM_DECADES-1:0] step;
  logic [DIGIT_W-1:0] tgt  [NUM_DECADES];
  logic [DIGIT_W-1:0] digs [NUM_DECADES];

  assign load_ok     = target_ok(tgt_tens, tgt_units);
  assign done        = armed && (&at_top);
  assign pulse_ready = armed && !done;
  assign accept      = pulse_valid && pulse_ready;
  assign tgt[UNITS]  = tgt_units;
  assign tgt[TENS]   = tgt_tens;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      bad_target <= 1'b0;
    end else if (load) begin
      armed      <= load_ok;
      bad_target <= !load_ok;
    end
  end

  swallow_prescaler #(.MOD_HI(MOD_HI)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (load),
    .adv    (accept),
    .div_lo (at_top[UNITS]),
    .tick   (tick)
  );

  for (genvar i = 0; i < NUM_DECADES; i++) begin : g_dec
    if (i == UNITS) begin : g_gated
      assign step[i] = tick && !at_top[i];
    end else begin : g_free
      assign step[i] = tick;
    end
    bcd_decade u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .preset     (load && load_ok),
      .preset_val (nines_comp(tgt[i])),
      .step       (step[i]),
      .digit      (digs[i]),
      .at_top     (at_top[i])
    );
  end

  assign dig_units = digs[UNITS];
  assign dig_tens  = digs[TENS];

  a_r5_units_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_units == DIGIT_TOP && !load) |=> (dig_units == DIGIT_TOP));
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (done && $stable(dig_tens) && $stable(dig_units)));
  a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !load_ok) |=> (bad_target && !pulse_ready && $stable(dig_tens) && $stable(dig_units)));
  a_r3_no_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !accept) |=> ($stable(dig_tens) && $stable(dig_units)));
  a_r4_joint_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dig_units != DIGIT_TOP && dig_units != $past(dig_units)) |-> (dig_tens != $past(dig_tens)));
endmodule

// File: tb/pulse_swallow_counter_test.sv
`timescale 1ns/1ps
module pulse_swallow_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] tgt_tens = '0;
  logic [3:0] tgt_units = '0;
  logic       pulse_valid = 1'b0;
  logic       pulse_ready, done, bad_target;
  logic [3:0] dig_tens, dig_units;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pulse_swallow_counter uut (
    .clk(clk), .rst_n(rst_n), .load(load), .tgt_tens(tgt_tens), .tgt_units(tgt_units),
    .pulse_valid(pulse_valid), .pulse_ready(pulse_ready), .done(done),
    .bad_target(bad_target), .dig_tens(dig_tens), .dig_units(dig_units)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_load(input int t, input int u);
    @(negedge clk);
    pulse_valid = 1'b0;
    load = 1'b1;
    tgt_tens = 4'(t);
    tgt_units = 4'(u);
    @(negedge clk);
    load = 1'b0;
  endtask

  // Expected digits after k accepted pulses, target t,u
  function automatic int ticks_after(input int k, input int u);
    if (k <= 11 * u) return k / 11;
    return u + (k - 11 * u) / 10;
  endfunction

  task automatic run_target(input int t, input int u, input int gap, input string done_tag);
    int n = 10 * t + u;
    int k = 0;
    int tk;
    do_load(t, u);
    check(bad_target == 1'b0, "R2 bad_target after good load", int'(bad_target), 0);
    check(int'(dig_tens) == 9 - t, "R2 preset tens", int'(dig_tens), 9 - t);
    check(int'(dig_units) == 9 - u, "R2 preset units", int'(dig_units), 9 - u);
    for (int it = 0; it < 400; it++) begin
      tk = ticks_after(k, u);
      check(int'(dig_tens) == 9 - t + tk, (k <= 11 * u) ? "R4 tens digit" : "R5 tens digit",
            int'(dig_tens), 9 - t + tk);
      check(int'(dig_units) == 9 - u + ((tk < u) ? tk : u),
            (k < 11 * u) ? "R4 units digit" : "R5 units frozen",
            int'(dig_units), 9 - u + ((tk < u) ? tk : u));
      check(pulse_ready == (k != n), "R3 ready", int'(pulse_ready), int'(k != n));
      if (k == n) begin
        check(done == 1'b1, done_tag, int'(done), 1);
        break;
      end
      check(done == 1'b0, done_tag, int'(done), 0);
      pulse_valid = (gap == 0) ? 1'b1 : (((it * 7 + t + u) % 5) != 0);
      if (pulse_valid) k++;
      @(negedge clk);
    end
    pulse_valid = 1'b1;
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      check(done == 1'b1, "R7 done held", int'(done), 1);
      check(dig_tens == 4'd9 && dig_units == 4'd9, "R7 digits held",
            int'(dig_tens) * 10 + int'(dig_units), 99);
    end
    pulse_valid = 1'b0;
  endtask

  initial begin
    #1_900_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] hold_t, hold_u;
    repeat (3) @(negedge clk);
    check(dig_tens == 0 && dig_units == 0, "R1 digits at reset",
          int'(dig_tens) * 10 + int'(dig_units), 0);
    check(!done && !pulse_ready && !bad_target, "R1 flags at reset",
          int'({done, pulse_ready, bad_target}), 0);
    rst_n = 1'b1;
    pulse_valid = 1'b1;
    repeat (2) @(negedge clk);
    check(dig_tens == 0 && dig_units == 0, "R3 no consume before load",
          int'(dig_tens) * 10 + int'(dig_units), 0);
    pulse_valid = 1'b0;

    // Sweep every accepted target, dense and gapped
    for (int t = 0; t <= 9; t++)
      for (int u = 0; u <= t; u++) begin
        run_target(t, u, 0, "R6 done instant");
        run_target(t, u, 1, "R10 done instant with gaps");
      end

    // Rejected targets
    hold_t = dig_tens;
    hold_u = dig_units;
    do_load(3, 7);
    check(bad_target == 1'b1, "R8 units above tens flagged", int'(bad_target), 1);
    check(pulse_ready == 1'b0 && done == 1'b0, "R8 disarmed", int'({pulse_ready, done}), 0);
    pulse_valid = 1'b1;
    repeat (12) @(negedge clk);
    check(dig_tens == hold_t && dig_units == hold_u, "R8 digits unchanged",
          int'(dig_tens) * 10 + int'(dig_units), int'(hold_t) * 10 + int'(hold_u));
    pulse_valid = 1'b0;
    do_load(10, 0);
    check(bad_target == 1'b1, "R8 non-BCD tens flagged", int'(bad_target), 1);
    check(dig_tens == hold_t && dig_units == hold_u, "R8 digits unchanged non-BCD",
          int'(dig_tens) * 10 + int'(dig_units), int'(hold_t) * 10 + int'(hold_u));
    do_load(5, 11);
    check(bad_target == 1'b1, "R8 non-BCD units flagged", int'(bad_target), 1);

    // Reload mid-run with a partial prescaler phase
    do_load(5, 4);
    pulse_valid = 1'b1;
    repeat (20) @(negedge clk);
    check(int'(dig_tens) == 5 && int'(dig_units) == 6, "R9 mid-run digits before reload",
          int'(dig_tens) * 10 + int'(dig_units), 56);
    run_target(3, 2, 0, "R9 restart done instant");
    do_load(7, 3);
    pulse_valid = 1'b1;
    repeat (9) @(negedge clk);
    run_target(6, 6, 1, "R9 restart done instant gapped");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule